// File: doc/BRIEF.md
# Serial-Programmed Audio Path Controller

This block takes an 8-bit control word from a three-wire serial bus (data, serial clock and an active-high frame enable) and turns it into the select and enable signals for an audio output stage with one speaker path and two headset paths. The serial pins are asynchronous to the block. Each one passes through a synchroniser, and its edges are detected on the block's own system clock. That clock must run at least four times faster than the serial clock.

Bits arrive least significant first, on rising serial-clock edges while the enable is high. When the enable drops, a complete word is copied into the active configuration register. The low three bits of the word choose one of eight routing modes. The upper five bits choose a gain step. The block drives the routing flags, the raw fields, and the gain as a signed number in half-dB units. It also gives a one-cycle pulse on each accepted word and a flag that shows a rejected short frame.

Top module: `ampc_top`

## Requirements
- R1: Data bits are captured only on rising serial-clock edges that occur while the enable is high.
- R2: The first captured bit is word bit 0. Word bits 2..0 are the mode (`cfg_mode`) and word bits 7..3 are the gain code (`cfg_gain`).
- R3: A word is committed when the enable falls. `commit_pulse` is high for exactly one system cycle on each commit.
- R4: If the enable falls after fewer than 8 captured bits, the active register is left unchanged and no pulse occurs. `frame_rejected` is set and stays set until the next commit clears it.
- R5: After the eighth bit, further serial-clock edges in the same enable window are ignored. The committed word is the first 8 bits.
- R6: `gain_hdb` is the two's-complement 8-bit value −69 + 3 × gain code, so code 0 gives −69 and code 31 gives +24.
- R7: After reset, the mode is 0 and the gain code is 27 (`gain_hdb` = 12). All path outputs are low, and `commit_pulse` and `frame_rejected` are low.
- R8: Mode 0 turns every path off. Mode 1 enables only the speaker, fed from the phone input (`spk_phone`). Mode 2 enables only both headsets, each fed from the phone input (`hp_phone`).
- R9: Mode 3 enables only the speaker, fed from the gained stereo sum (`spk_mix`). Mode 4 enables only both headsets, each fed from its gained stereo input (`hp_stereo`). Mode 5 enables the speaker with both `spk_mix` and `spk_phone`.
- R10: Mode 6 enables both headsets with both `hp_phone` and `hp_stereo`, and the speaker is off. Mode 7 is the same as mode 6, and in addition enables the speaker with `spk_phone` only.
- R11: Serial-clock and data activity while the enable is low changes no output and leaves no bits for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_en | input | 1 | Frame enable, active high, asynchronous |
| cfg_mode | output | 3 | Active routing mode |
| cfg_gain | output | 5 | Active gain code |
| gain_hdb | output | 8 | Signed gain in 0.5 dB units |
| spk_on | output | 1 | Speaker path enabled |
| spk_phone | output | 1 | Speaker fed from the phone input at +6 dB |
| spk_mix | output | 1 | Speaker fed from the gained stereo sum |
| hp_on | output | 2 | Headset path enabled, bit 0 left, bit 1 right |
| hp_phone | output | 2 | Headset fed from the phone input at 0 dB, bit 0 left |
| hp_stereo | output | 2 | Headset fed from its gained stereo input, bit 0 left |
| commit_pulse | output | 1 | One-cycle strobe on each accepted word |
| frame_rejected | output | 1 | Set by a short frame, cleared by the next commit |

## Verification
The hardest cases to reach from the ports are the frame-length corners. These are a frame that ends before its eighth bit (including one with no bits at all) and a frame that keeps clocking well past its eighth bit. In both, the active register must keep or take the right contents. The bench's frame task takes a bit count that is independent of the word width, so it can send short, exact and long frames. It also has a separate task that toggles the serial clock and data with the enable low. After each of these, a full frame loads a known word, which shows that no stray bits were left in the receiver.

// File: rtl/ampc_pkg.sv
package ampc_pkg;
  localparam int WORD_W = 8;
  localparam int MODE_W = 3;
  localparam int GAIN_W = WORD_W - MODE_W;
  localparam int HP_CH  = 2;

  typedef enum logic [MODE_W-1:0] {
    MD_STANDBY    = 3'd0,
    MD_SPK_PHONE  = 3'd1,
    MD_HP_PHONE   = 3'd2,
    MD_SPK_STEREO = 3'd3,
    MD_HP_STEREO  = 3'd4,
    MD_SPK_BOTH   = 3'd5,
    MD_HP_MIX     = 3'd6,
    MD_ALL        = 3'd7
  } mode_e;

  typedef struct packed {
    logic [GAIN_W-1:0] gain;
    logic [MODE_W-1:0] mode;
  } ctrl_word_t;
endpackage

// File: rtl/ampc_sync.sv
module ampc_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] q;
    logic [STAGES-1:0] d;

    always_comb d = {q[STAGES-2:0], din[i]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign dout[i] = q[STAGES-1];
  end
endmodule

// File: rtl/ampc_frame_rx.sv
module ampc_frame_rx
  import ampc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_clk,
  input  logic              s_en,
  input  logic              s_dat,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o,
  output logic              reject_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic              prev_clk_q, prev_en_q;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              commit_q, commit_d, reject_q, reject_d;
  logic              clk_rise, en_fall, full;

  always_comb begin
    clk_rise = s_clk & ~prev_clk_q;
    en_fall  = ~s_en & prev_en_q;
    full     = (cnt_q == CNT_W'(WORD_W));
    shreg_d  = shreg_q;
    cnt_d    = cnt_q;
    if (!s_en) begin
      cnt_d = '0;
    end else if (clk_rise && !full) begin
      shreg_d = {s_dat, shreg_q[WORD_W-1:1]};
      cnt_d   = cnt_q + CNT_W'(1);
    end
    commit_d = en_fall & full;
    reject_d = en_fall & ~full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_clk_q <= 1'b0;
      prev_en_q  <= 1'b0;
      shreg_q    <= '0;
      cnt_q      <= '0;
      commit_q   <= 1'b0;
      reject_q   <= 1'b0;
    end else begin
      prev_clk_q <= s_clk;
      prev_en_q  <= s_en;
      shreg_q    <= shreg_d;
      cnt_q      <= cnt_d;
      commit_q   <= commit_d;
      reject_q   <= reject_d;
    end
  end

  assign word_o   = shreg_q;
  assign commit_o = commit_q;
  assign reject_o = reject_q;

  // R5: a full word is frozen for the rest of the window
  assert_full_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_en && full) |=> $stable(shreg_q));
  // R11: nothing shifts while the enable is low
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_en) |=> $stable(shreg_q));
  // R4: a window never both commits and rejects
  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_q && reject_q));
endmodule

// File: rtl/ampc_route.sv
module ampc_route
  import ampc_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output logic              spk_on,
  output logic              spk_phone,
  output logic              spk_mix,
  output logic [HP_CH-1:0]  hp_on,
  output logic [HP_CH-1:0]  hp_phone,
  output logic [HP_CH-1:0]  hp_stereo
);
  logic hp_en, hp_ph, hp_st;

  always_comb begin
    spk_phone = 1'b0;
    spk_mix   = 1'b0;
    hp_ph     = 1'b0;
    hp_st     = 1'b0;
    unique case (mode_e'(mode))
      MD_STANDBY:    ;
      MD_SPK_PHONE:  spk_phone = 1'b1;
      MD_HP_PHONE:   hp_ph     = 1'b1;
      MD_SPK_STEREO: spk_mix   = 1'b1;
      MD_HP_STEREO:  hp_st     = 1'b1;
      MD_SPK_BOTH:   begin spk_mix = 1'b1; spk_phone = 1'b1; end
      MD_HP_MIX:     begin hp_ph = 1'b1; hp_st = 1'b1; end
      MD_ALL:        begin hp_ph = 1'b1; hp_st = 1'b1; spk_phone = 1'b1; end
      default:       ;
    endcase
    spk_on = spk_phone | spk_mix;
    hp_en  = hp_ph | hp_st;
  end

  for (genvar c = 0; c < HP_CH; c++) begin : g_hp
    assign hp_on[c]     = hp_en;
    assign hp_phone[c]  = hp_ph;
    assign hp_stereo[c] = hp_st;
  end
endmodule

// File: rtl/ampc_top.sv
module ampc_top
  import ampc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RESET_GAIN  = 27,
  parameter int GAIN_BASE   = -69,
  parameter int GAIN_STEP   = 3,
  parameter int GAIN_OUT_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ser_dat,
  input  logic                         ser_clk,
  input  logic                         ser_en,
  output logic [2:0]                   cfg_mode,
  output logic [4:0]                   cfg_gain,
  output logic signed [GAIN_OUT_W-1:0] gain_hdb,
  output logic                         spk_on,
  output logic                         spk_phone,
  output logic                         spk_mix,
  output logic [1:0]                   hp_on,
  output logic [1:0]                   hp_phone,
  output logic [1:0]                   hp_stereo,
  output logic                         commit_pulse,
  output logic                         frame_rejected
);
  localparam int GAIN_MAX = GAIN_BASE + GAIN_STEP * ((1 << GAIN_W) - 1);

  logic [2:0]        sync_q;
  logic [WORD_W-1:0] rx_word;
  logic              rx_commit, rx_reject;
  ctrl_word_t        ctrl_q, ctrl_d;
  logic              pulse_q, pulse_d, rej_q, rej_d;

  ampc_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({ser_en, ser_clk, ser_dat}),
    .dout(sync_q)
  );

  ampc_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .s_clk(sync_q[1]), .s_en(sync_q[2]), .s_dat(sync_q[0]),
    .word_o(rx_word), .commit_o(rx_commit), .reject_o(rx_reject)
  );

  always_comb begin
    ctrl_d  = rx_commit ? ctrl_word_t'(rx_word) : ctrl_q;
    pulse_d = rx_commit;
    rej_d   = rej_q;
    if (rx_commit)      rej_d = 1'b0;
    else if (rx_reject) rej_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.mode <= MD_STANDBY;
      ctrl_q.gain <= GAIN_W'(RESET_GAIN);
      pulse_q     <= 1'b0;
      rej_q       <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      pulse_q <= pulse_d;
      rej_q   <= rej_d;
    end
  end

  ampc_route u_route (
    .mode(ctrl_q.mode),
    .spk_on(spk_on), .spk_phone(spk_phone), .spk_mix(spk_mix),
    .hp_on(hp_on), .hp_phone(hp_phone), .hp_stereo(hp_stereo)
  );

  always_comb gain_hdb = GAIN_OUT_W'(GAIN_BASE + GAIN_STEP * int'(ctrl_q.gain));

  assign cfg_mode       = ctrl_q.mode;
  assign cfg_gain       = ctrl_q.gain;
  assign commit_pulse   = pulse_q;
  assign frame_rejected = rej_q;

  // R3: the active word only moves together with the commit strobe
  assert_load_with_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> commit_pulse);
  // R3: the strobe never lasts two cycles
  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> !commit_pulse);
  // R4: a commit leaves the rejection flag clear
  assert_commit_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> !frame_rejected);
  // R6: gain stays inside the coded range
  assert_gain_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(gain_hdb) >= GAIN_BASE) && (int'(gain_hdb) <= GAIN_MAX));
  // R8: standby leaves every path dark
  assert_standby_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'd0) |-> (!spk_on && hp_on == 2'b00));
  // R9: an enabled speaker always has a source
  assert_spk_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    spk_on |-> (spk_phone || spk_mix));
endmodule

// File: tb/ampc_top_test.sv
module ampc_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_dat = 1'b0, ser_clk = 1'b0, ser_en = 1'b0;
  logic [2:0] cfg_mode;
  logic [4:0] cfg_gain;
  logic signed [7:0] gain_hdb;
  logic spk_on, spk_phone, spk_mix, commit_pulse, frame_rejected;
  logic [1:0] hp_on, hp_phone, hp_stereo;

  int checks = 0, errors = 0;
  int n_pulse = 0, n_wide = 0;
  logic prev_pulse = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  ampc_top uut (
    .clk(clk), .rst_n(rst_n), .ser_dat(ser_dat), .ser_clk(ser_clk), .ser_en(ser_en),
    .cfg_mode(cfg_mode), .cfg_gain(cfg_gain), .gain_hdb(gain_hdb),
    .spk_on(spk_on), .spk_phone(spk_phone), .spk_mix(spk_mix),
    .hp_on(hp_on), .hp_phone(hp_phone), .hp_stereo(hp_stereo),
    .commit_pulse(commit_pulse), .frame_rejected(frame_rejected)
  );

  always @(posedge clk) begin
    if (commit_pulse) n_pulse++;
    if (commit_pulse && prev_pulse) n_wide++;
    prev_pulse <= commit_pulse;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nbits may be shorter or longer than the word
  task automatic send_frame(input logic [15:0] bits, input int nbits);
    ser_en = 1'b1;
    wait_cyc(4);
    for (int i = 0; i < nbits; i++) begin
      ser_dat = bits[i];
      wait_cyc(4);
      ser_clk = 1'b1;
      wait_cyc(4);
      ser_clk = 1'b0;
    end
    wait_cyc(4);
    ser_en = 1'b0;
    wait_cyc(12);
  endtask

  // speaker on/phone/mix, hp_on, hp_phone, hp_stereo
  function automatic int exp_route(input int m);
    case (m)
      0: return 9'b000_00_00_00;
      1: return 9'b110_00_00_00;
      2: return 9'b000_11_11_00;
      3: return 9'b101_00_00_00;
      4: return 9'b000_11_00_11;
      5: return 9'b111_00_00_00;
      6: return 9'b000_11_11_11;
      default: return 9'b110_11_11_11;
    endcase
  endfunction

  function automatic int act_route();
    return int'({spk_on, spk_phone, spk_mix, hp_on, hp_phone, hp_stereo});
  endfunction

  task automatic t_reset();
    chk("R7 mode", cfg_mode, 0);
    chk("R7 gain code", cfg_gain, 27);
    chk("R7 gain_hdb", int'(gain_hdb), 12);
    chk("R7 paths off", act_route(), 0);
    chk("R7 pulse", commit_pulse, 0);
    chk("R7 reject flag", frame_rejected, 0);
  endtask

  task automatic t_modes();
    for (int m = 0; m < 8; m++) begin
      int g = (m * 5 + 2) % 32;
      int p0 = n_pulse;
      send_frame(16'((g << 3) | m), 8);
      chk("R2 mode field", cfg_mode, m);
      chk("R2 gain field", cfg_gain, g);
      chk("R3 one pulse", n_pulse - p0, 1);
      if (m < 3)      chk("R8 routing", act_route(), exp_route(m));
      else if (m < 6) chk("R9 routing", act_route(), exp_route(m));
      else            chk("R10 routing", act_route(), exp_route(m));
    end
    chk("R3 pulse width", n_wide, 0);
  endtask

  task automatic t_gain();
    send_frame(16'h0003, 8);
    chk("R6 code 0", int'(gain_hdb), -69);
    send_frame(16'h00FB, 8);
    chk("R6 code 31", int'(gain_hdb), 24);
    send_frame(16'h0084, 8);
    chk("R6 code 16", int'(gain_hdb), -21);
  endtask

  task automatic t_short();
    int p0;
    send_frame(16'h0056, 8);   // mode 6, gain 10
    p0 = n_pulse;
    send_frame(16'h00FF, 5);
    chk("R4 mode kept", cfg_mode, 6);
    chk("R4 gain kept", cfg_gain, 10);
    chk("R4 no pulse", n_pulse - p0, 0);
    chk("R4 flag set", frame_rejected, 1);
    send_frame(16'h0000, 0);
    chk("R4 empty frame kept", cfg_mode, 6);
    chk("R4 flag held", frame_rejected, 1);
    send_frame(16'h0029, 8);   // mode 1, gain 5
    chk("R4 flag cleared", frame_rejected, 0);
    chk("R4 later commit", cfg_mode, 1);
  endtask

  task automatic t_long();
    send_frame(16'hF35C, 16);  // first 8 bits 0x5C
    chk("R5 mode first bits", cfg_mode, 4);
    chk("R5 gain first bits", cfg_gain, 11);
    chk("R5 routing", act_route(), exp_route(4));
  endtask

  task automatic t_idle();
    int p0 = n_pulse;
    send_frame(16'h00C7, 8);   // mode 7, gain 24
    p0 = n_pulse;
    ser_dat = 1'b1;
    for (int i = 0; i < 10; i++) begin
      wait_cyc(4); ser_clk = 1'b1;
      wait_cyc(4); ser_clk = 1'b0;
    end
    wait_cyc(12);
    chk("R11 mode", cfg_mode, 7);
    chk("R11 gain", cfg_gain, 24);
    chk("R11 no pulse", n_pulse - p0, 0);
    chk("R11 no reject", frame_rejected, 0);
    send_frame(16'h0002, 8);
    chk("R1 clean next frame mode", cfg_mode, 2);
    chk("R1 clean next frame gain", cfg_gain, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(3);
    t_reset();
    t_modes();
    t_gain();
    t_short();
    t_long();
    t_idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule